// File: doc/BRIEF.md
# Enable-Gated Reset Release Synchronizer

This block turns an asynchronous, active-low reset request into an active-high reset for one clock domain. Asserting the request forces the output reset active at once, with no clock edge needed. Release happens only on clock edges, and only after a device-wide start enable has been seen high on the destination clock.

Once that sampled enable is high, a set bit ripples through a short chain of flip-flops, one stage per rising edge. The output is the NAND of every stage, so the reset stays active until the whole chain has filled. The chain length is a parameter. Choose it so that the release window is longer than the worst skew of the start enable across the device. A separate parameter sets the depth of the enable sampler.

Place one instance per clock domain, next to the logic it resets. Drive the request from the asynchronous reset source and the enable from the global start signal.

Top module: `reset_release_sync`

## Requirements
- R1: Within the same clock cycle that the request input goes low, and without waiting for any clock edge, the reset output becomes 1.
- R2: While the request input is low, the reset output stays 1 on every clock edge, whatever the start enable does.
- R3: The start enable takes effect only through a sampler clocked on the destination clock (default depth 1). On any edge where the sampled enable is 0, the chain keeps its contents and no release progress is made or lost.
- R4: Count from the first rising edge at which the request is high and the enable is high, with the enable kept high. The reset output becomes 0 on exactly the (SYNC_DEPTH + CHAIN_LEN)-th such edge. With the defaults (1 and 3) this is the 4th edge, and the output is 1 before it.
- R5: Once the reset output has become 0, it stays 0 for as long as the request stays high, even if the start enable drops. This includes the enable dropping on the very edge that completes the release.
- R6: If the request goes low at any point during release, including just before the completing edge, all progress is lost. After the request returns high, a full count as in R4 is needed again.
- R7: The reset output is 1 whenever any chain stage is 0, and stages fill strictly in order from the first to the last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination domain clock |
| arst_req_n | input | 1 | Asynchronous reset request, active low |
| start_en_i | input | 1 | Global start enable, asynchronous to clk |
| rst_o | output | 1 | Synchronized reset for the domain, active high |

## Verification
Two events can land in the same cycle: a new reset request and the completing step of a release. The bench provokes this by pulling the request low half a cycle before the edge that would release the reset. It then expects the output to stay active and the full count to start again, and treats any early or missed release as a failure. The bench also drops the enable on the completing edge itself. There it expects the release to go through, because the sampler still holds the earlier high value at that edge, and it expects the output to stay inactive afterwards.

// File: rtl/rsr_pkg.sv
// Package: shared defaults for the reset release synchronizer.
// Assumes: the consumers take these as parameter defaults only.
package rsr_pkg;
    // Default number of release flip-flops in the chain.
    localparam int unsigned RSR_CHAIN_LEN_DEF  = 3;
    // Default number of flops that sample the start enable.
    localparam int unsigned RSR_SYNC_DEPTH_DEF = 1;
endpackage

// File: rtl/rsr_enable_sampler.sv
// Module: rsr_enable_sampler
// Samples the global start enable on the destination clock through a
// short flop line, so that a mid-cycle change cannot cause a partial release.
// Assumes: SYNC_DEPTH >= 1; arst_req_n clears every flop asynchronously.
module rsr_enable_sampler #(
    parameter int unsigned SYNC_DEPTH = 1
) (
    input  logic clk,
    input  logic arst_req_n,
    input  logic start_en_i,
    output logic adv_o
);

    logic [SYNC_DEPTH-1:0] smp_q;

    for (genvar i = 0; i < SYNC_DEPTH; i++) begin : g_smp
        logic d;
        if (i == 0) begin : g_first
            assign d = start_en_i;
        end else begin : g_next
            assign d = smp_q[i-1];
        end
        // Sampling flop, cleared at once by the reset request.
        always_ff @(posedge clk or negedge arst_req_n) begin
            if (!arst_req_n) smp_q[i] <= 1'b0;
            else             smp_q[i] <= d;
        end
    end

    assign adv_o = smp_q[SYNC_DEPTH-1];

    // A low enable must be seen low by the first sampler after the edge.
    assert_en_gate_R3: assert property (@(posedge clk) disable iff (!arst_req_n)
        !start_en_i |=> !smp_q[0]);

endmodule

// File: rtl/rsr_release_chain.sv
// Module: rsr_release_chain
// Ripples a set bit through CHAIN_LEN flops, one stage per edge on which
// the sampled enable is high; holds every stage when it is low.
// Assumes: adv_i is synchronous to clk; arst_req_n clears all stages.
module rsr_release_chain #(
    parameter int unsigned CHAIN_LEN = 3
) (
    input  logic                 clk,
    input  logic                 arst_req_n,
    input  logic                 adv_i,
    output logic [CHAIN_LEN-1:0] stage_o
);

    logic [CHAIN_LEN-1:0] stage_q;

    for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
        logic d;
        if (i == 0) begin : g_head
            assign d = 1'b1;
        end else begin : g_tail
            assign d = stage_q[i-1];
        end
        // Release stage: cleared by the request, advances only when enabled.
        always_ff @(posedge clk or negedge arst_req_n) begin
            if (!arst_req_n)  stage_q[i] <= 1'b0;
            else if (adv_i)   stage_q[i] <= d;
        end
        if (i > 0) begin : g_order
            // Stages fill in order: a later stage set implies the one before.
            assert_fill_order_R7: assert property (@(posedge clk) disable iff (!arst_req_n)
                stage_q[i] |-> stage_q[i-1]);
        end
    end

    assign stage_o = stage_q;

    // No enable, no movement in the chain.
    assert_hold_R3: assert property (@(posedge clk) disable iff (!arst_req_n)
        !adv_i |=> $stable(stage_q));

    // An enabled edge always sets the head stage.
    assert_head_set_R4: assert property (@(posedge clk) disable iff (!arst_req_n)
        adv_i |=> stage_q[0]);

endmodule

// File: rtl/rsr_reset_combiner.sv
// Module: rsr_reset_combiner
// Forms the output reset as the NAND of all chain stages, so reset stays
// active until every stage has filled.
// Assumes: stage_i comes straight from flops (glitch-free combination).
module rsr_reset_combiner #(
    parameter int unsigned CHAIN_LEN = 3
) (
    input  logic [CHAIN_LEN-1:0] stage_i,
    output logic                 rst_o
);

    // Reset is active while any stage is still clear.
    assign rst_o = ~&stage_i;

endmodule

// File: rtl/reset_release_sync.sv
// Module: reset_release_sync (top)
// Asynchronous-assert, enable-gated synchronous-release reset for one domain.
// Assumes: one clock domain; CHAIN_LEN chosen to exceed start-enable skew.
module reset_release_sync
    import rsr_pkg::*;
#(
    parameter int unsigned CHAIN_LEN  = RSR_CHAIN_LEN_DEF,
    parameter int unsigned SYNC_DEPTH = RSR_SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic arst_req_n,
    input  logic start_en_i,
    output logic rst_o
);

    logic                 adv;
    logic [CHAIN_LEN-1:0] stage;

    rsr_enable_sampler #(.SYNC_DEPTH(SYNC_DEPTH)) u_sampler (
        .clk        (clk),
        .arst_req_n (arst_req_n),
        .start_en_i (start_en_i),
        .adv_o      (adv)
    );

    rsr_release_chain #(.CHAIN_LEN(CHAIN_LEN)) u_chain (
        .clk        (clk),
        .arst_req_n (arst_req_n),
        .adv_i      (adv),
        .stage_o    (stage)
    );

    rsr_reset_combiner #(.CHAIN_LEN(CHAIN_LEN)) u_comb (
        .stage_i    (stage),
        .rst_o      (rst_o)
    );

    // While the request is held, the output must be active at every edge.
    always @(posedge clk) begin
        if (!arst_req_n) begin
            assert_active_in_req_R2: assert (rst_o);
        end
    end

    // Once released, the output never comes back without a new request.
    assert_sticky_release_R5: assert property (@(posedge clk) disable iff (!arst_req_n)
        !rst_o |=> !rst_o);

    // Release only follows an enabled edge.
    assert_release_needs_en_R4: assert property (@(posedge clk) disable iff (!arst_req_n)
        $fell(rst_o) |-> $past(adv));

endmodule

// File: tb/reset_release_sync_tb_top.sv
// Scoreboard bench: the driver pushes expected reset values per edge,
// the monitor pops and compares them after each rising edge.
module reset_release_sync_tb_top;

    localparam int unsigned LEN   = 3;
    localparam int unsigned DEPTH = 1;
    localparam int unsigned NREL  = LEN + DEPTH;

    logic clk = 1'b0;
    logic arst_req_n = 1'b1;
    logic start_en_i = 1'b0;
    logic rst_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  exp_rst;
        string tag;
    } item_t;
    item_t sb_q[$];

    // Reference model state: progress count and sampled-enable history.
    int          prog   = 0;
    logic [DEPTH-1:0] en_ref = '0;

    always #4 clk = ~clk;

    reset_release_sync #(.CHAIN_LEN(LEN), .SYNC_DEPTH(DEPTH)) dut_i (
        .clk        (clk),
        .arst_req_n (arst_req_n),
        .start_en_i (start_en_i),
        .rst_o      (rst_o)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("[TB] FAIL %s: rst_o actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: set inputs mid-cycle, update model for the next edge, push expectation.
    task automatic step(input logic rq, input logic en, input string tag);
        item_t it;
        @(negedge clk);
        arst_req_n = rq;
        start_en_i = en;
        if (!rq) begin
            prog   = 0;
            en_ref = '0;
            #1;
            check(rst_o, 1'b1, {tag, " async"});
        end
        if (rq) begin
            if (en_ref[DEPTH-1] && prog < LEN) prog++;
            en_ref = (DEPTH > 1) ? {en_ref[DEPTH-2:0], en} : {{(DEPTH-1){1'b0}}, en};
            it.exp_rst = (prog < LEN);
        end else begin
            it.exp_rst = 1'b1;
        end
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare each edge's result against the queued expectation.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                check(rst_o, it.exp_rst, it.tag);
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("[TB] FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Reset state: request raised before the first edge.
        #3;
        arst_req_n = 1'b0;
        #1;
        check(rst_o, 1'b1, "R1 reset state");

        // R2: request held, enable toggled.
        repeat (3) step(1'b0, 1'b0, "R2 held");
        repeat (2) step(1'b0, 1'b1, "R2 held with enable");

        // R3: request removed, enable low: no release.
        repeat (5) step(1'b1, 1'b0, "R3 enable low");

        // R4: release exactly NREL edges after both conditions.
        for (int k = 1; k <= 6; k++) step(1'b1, 1'b1, "R4 release count");

        // R5: enable drops after release: stays released.
        repeat (4) step(1'b1, 1'b0, "R5 stays released");
        repeat (2) step(1'b1, 1'b1, "R5 stays released");

        // R1 and R6: mid-release request restarts the count.
        step(1'b0, 1'b1, "R1 async assert");
        repeat (2) step(1'b1, 1'b1, "R6 partial");
        step(1'b0, 1'b1, "R6 request mid-release");
        repeat (6) step(1'b1, 1'b1, "R6 full restart");

        // R3: enable paused mid-release, progress kept.
        step(1'b0, 1'b0, "R3 pause prep");
        repeat (2) step(1'b1, 1'b1, "R3 pause start");
        repeat (3) step(1'b1, 1'b0, "R3 paused");
        repeat (5) step(1'b1, 1'b1, "R3 resume");

        // R6: request arrives just before the completing edge.
        step(1'b0, 1'b0, "R6 coincide prep");
        repeat (NREL - 1) step(1'b1, 1'b1, "R6 coincide run");
        step(1'b0, 1'b1, "R6 coincide request");
        repeat (6) step(1'b1, 1'b1, "R6 coincide restart");

        // R5 and R7: enable drops on the completing edge; release still occurs.
        step(1'b0, 1'b0, "R5 last edge prep");
        repeat (NREL - 1) step(1'b1, 1'b1, "R7 filling");
        step(1'b1, 1'b0, "R5 enable drop at completion");
        repeat (3) step(1'b1, 1'b0, "R5 after completion");

        repeat (2) @(posedge clk);
        #3;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule